// File: doc/BRIEF.md
# I2C Master Controller with Interrupt Handshake

This block is a memory-mapped I2C bus master. Software sees five byte-wide registers: control, status, own address, data shift and line control. A status write in a master mode with the start bit set produces a START condition and then shifts the data register out as the address byte. Its upper seven bits are the target address and bit 0 is the read/write flag. Each later byte is either transmitted from the data register or received into it. After every byte the controller parks with SCL held low and, if interrupts are enabled, raises a pending flag that drives the interrupt line. Software then reads or writes the data register and clears the pending flag, and the next byte goes out. A status write in a master mode with the start bit clear produces a STOP.

The design has three parts. A quarter-period tick generator divides the system clock by `QTR_DIV`. A bit engine state machine produces START, nine-clock bytes and STOP on open-drain SCL and SDA. Each line is driven low through a `*_low` output and released otherwise. The top level holds the register file and the handshake.

The bit engine states are as follows. `ST_IDLE` has both lines released, and `ST_HOLD` holds SCL low between bytes. `ST_STA_A`, `ST_STA_B` and `ST_STA_C` form START: SDA is released with SCL low, then SCL rises, then SDA falls while SCL is high. `ST_BIT` covers one bit in four quarters: SCL is low in quarters 0 and 1, SDA changes at the end of quarter 0, SCL is high in quarters 2 and 3, and SDA is sampled at the end of quarter 3. `ST_STO_A`, `ST_STO_B` and `ST_STO_C` form STOP: SDA is pulled low, then SCL rises, then SDA rises.

The transitions are as follows. From `ST_IDLE` or `ST_HOLD`, a start command goes to `ST_STA_A`, a transmit or receive command goes to `ST_BIT`, and a stop command goes to `ST_STO_A`. `ST_STA_C` goes to `ST_BIT`. After the ninth bit, `ST_BIT` goes to `ST_HOLD` and pulses `done`. `ST_STO_C` goes to `ST_IDLE`. An abort sends every state to `ST_IDLE`.

Top module: `i2cm_ctrl`

## Requirements
- R1: Registers decode at byte offsets 0x00 control, 0x04 status, 0x08 own address, 0x0C data and 0x10 line control. The line control register reads back what was written, and reads of any other offset return 0x00.
- R2: Control bit 7 is ACK enable, bit 5 is interrupt enable and bit 4 is the pending flag. A control write can clear the pending flag but never set it, and `irq` equals the pending flag.
- R3: Status bits [7:6] select the mode: 2'b11 is master transmit and 2'b10 is master receive. A status write with bit 7, bit 4 and bit 5 set clears status bit 0, sets busy (bit 5) and generates START. It then sends the data register MSB first, with bits [7:1] as the target address and bit 0 as the read/write flag.
- R4: A status write with bit 4 (output enable) clear forces busy low, clears the pending flag and `irq`, and releases SCL and SDA.
- R5: A status write with bit 7 set and bit 5 clear generates STOP when the engine is holding the bus. Busy is cleared only if no interrupt is pending.
- R6: After an address byte or a transmitted byte, status bit 0 becomes 1 only if ACK enable is set and the target left SDA high on the ninth clock. The pending flag is raised only when interrupt enable is set.
- R7: A control write that clears a set pending flag while busy resumes the transfer when the written interrupt-enable bit is 1: master transmit sends the data register, and master receive receives the next byte into it. When that bit is 0, busy is cleared and no byte follows.
- R8: The data register can be written only while output enable is 1. The own-address register can be written only while output enable is 0.
- R9: After reset, control, status and line control read 0x00, data and own address read 0xFF, `irq` is 0 and both lines are released.
- R10: Received bytes are assembled MSB first. On the ninth clock of a received byte, the master pulls SDA low when ACK enable is 1 and leaves it released when ACK enable is 0.
- R11: While the pending flag is set and the engine is holding after a byte, SCL stays driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a data read can start a receive) |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt, equal to the pending flag |
| scl_low | output | 1 | Drive SCL low when 1; release when 0 |
| sda_low | output | 1 | Drive SDA low when 1; release when 0 |
| sda_in | input | 1 | Sampled level of the SDA line |

## Verification
The bench builds the controller with `QTR_DIV` = 2, so one SCL period is eight system clocks and a full byte with its handshake fits in under a hundred cycles. This makes write, NACK, receive, repeated-byte and STOP sequences affordable in one short run. A behavioural target on the open-drain bus decodes START, STOP and bytes, ACKs only its own address and NACKs one data value. It also returns a fixed receive pattern, which exercises every ACK and NACK combination that status bit 0 and the master's ninth-clock drive depend on.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_HOLD, ST_STA_A, ST_STA_B, ST_STA_C,
        ST_BIT, ST_STO_A, ST_STO_B, ST_STO_C
    } eng_state_t;

    typedef enum logic [1:0] {CMD_START, CMD_TX, CMD_RX, CMD_STOP} eng_cmd_t;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_OWN  = 8'h08;
    localparam logic [7:0] OFS_DATA = 8'h0C;
    localparam logic [7:0] OFS_LINE = 8'h10;

    localparam logic [1:0] MODE_MRX = 2'b10;
    localparam logic [1:0] MODE_MTX = 2'b11;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int QTR_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int CW = (QTR_DIV > 1) ? $clog2(QTR_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear || cnt_q == LAST) cnt_q <= '0;
        else                                  cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cmd_valid,
    input  eng_cmd_t   cmd,
    input  logic [7:0] tx_byte,
    input  logic       ack_en,
    input  logic       abort,
    input  logic       sda_in,
    output logic       ready,
    output logic       holding,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       nack,
    output logic       scl_low,
    output logic       sda_low
);
    eng_state_t state_q;
    logic [1:0] qtr_q;
    logic [3:0] bit_q;
    logic [7:0] shreg_q;
    logic       rx_mode_q;
    logic       sda_rel_q;

    assign ready   = (state_q == ST_IDLE) || (state_q == ST_HOLD);
    assign holding = (state_q == ST_HOLD);
    assign rx_byte = shreg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            qtr_q     <= '0;
            bit_q     <= '0;
            shreg_q   <= '0;
            rx_mode_q <= 1'b0;
            sda_rel_q <= 1'b1;
            nack      <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                state_q   <= ST_IDLE;
                sda_rel_q <= 1'b1;
            end else if (cmd_valid && ready) begin
                qtr_q <= '0;
                bit_q <= '0;
                unique case (cmd)
                    CMD_START: begin
                        state_q <= ST_STA_A; shreg_q <= tx_byte;
                        rx_mode_q <= 1'b0;   sda_rel_q <= 1'b1;
                    end
                    CMD_TX: begin
                        state_q <= ST_BIT; shreg_q <= tx_byte; rx_mode_q <= 1'b0;
                    end
                    CMD_RX: begin
                        state_q <= ST_BIT; shreg_q <= '0; rx_mode_q <= 1'b1;
                    end
                    CMD_STOP: begin
                        state_q <= ST_STO_A; sda_rel_q <= 1'b0;
                    end
                endcase
            end else if (tick) begin
                unique case (state_q)
                    ST_IDLE, ST_HOLD: ;
                    ST_STA_A: state_q <= ST_STA_B;
                    ST_STA_B: begin state_q <= ST_STA_C; sda_rel_q <= 1'b0; end
                    ST_STA_C: begin state_q <= ST_BIT; qtr_q <= '0; bit_q <= '0; end
                    ST_BIT: begin
                        qtr_q <= qtr_q + 2'd1;
                        if (qtr_q == 2'd0) begin
                            if (bit_q == 4'd8) sda_rel_q <= rx_mode_q ? !ack_en : 1'b1;
                            else               sda_rel_q <= rx_mode_q ? 1'b1 : shreg_q[7];
                        end
                        if (qtr_q == 2'd3) begin
                            if (bit_q == 4'd8) begin
                                nack    <= sda_in;
                                done    <= 1'b1;
                                state_q <= ST_HOLD;
                            end else begin
                                shreg_q <= {shreg_q[6:0], sda_in};
                                bit_q   <= bit_q + 4'd1;
                            end
                        end
                    end
                    ST_STO_A: state_q <= ST_STO_B;
                    ST_STO_B: begin state_q <= ST_STO_C; sda_rel_q <= 1'b1; end
                    ST_STO_C: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        sda_low = !sda_rel_q;
        unique case (state_q)
            ST_HOLD, ST_STA_A, ST_STO_A: scl_low = 1'b1;
            ST_BIT:                      scl_low = !qtr_q[1];
            default:                     scl_low = 1'b0;
        endcase
    end

    // R10: SDA never moves in the high half of a bit clock
    assert_sda_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BIT && qtr_q == 2'd3) |-> $stable(sda_rel_q));
    // R6: a byte completion only follows a bit state
    assert_done_after_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state_q == ST_BIT));
    // R10: bit index never runs past the ninth clock
    assert_bit_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BIT) |-> (bit_q <= 4'd8));
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
    import i2cm_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int QTR_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq,
    output logic              scl_low,
    output logic              sda_low,
    input  logic              sda_in
);
    logic [7:0] ctrl_q, stat_q, own_q, data_q, line_q;
    logic       rx_inflight_q;

    logic hit_ctrl, hit_stat, hit_own, hit_data, hit_line;
    assign hit_ctrl = (reg_addr == ADDR_W'(OFS_CTRL));
    assign hit_stat = (reg_addr == ADDR_W'(OFS_STAT));
    assign hit_own  = (reg_addr == ADDR_W'(OFS_OWN));
    assign hit_data = (reg_addr == ADDR_W'(OFS_DATA));
    assign hit_line = (reg_addr == ADDR_W'(OFS_LINE));

    logic wr_ctrl, wr_stat, wr_data, rd_data, pend_clear;
    assign wr_ctrl    = reg_wr && hit_ctrl;
    assign wr_stat    = reg_wr && hit_stat;
    assign wr_data    = reg_wr && hit_data;
    assign rd_data    = reg_rd && hit_data;
    assign pend_clear = wr_ctrl && ctrl_q[4] && !reg_wdata[4];

    logic       cmd_valid, abort, launch, tick;
    logic       eng_ready, eng_hold, eng_done, eng_nack;
    logic [7:0] eng_rx;
    eng_cmd_t   cmd;

    always_comb begin
        cmd_valid = 1'b0;
        cmd       = CMD_TX;
        abort     = 1'b0;
        if (pend_clear && reg_wdata[5] && stat_q[5]) begin
            if (stat_q[7:6] == MODE_MTX) begin cmd_valid = 1'b1; cmd = CMD_TX; end
            else if (stat_q[7:6] == MODE_MRX) begin cmd_valid = 1'b1; cmd = CMD_RX; end
        end
        if (wr_stat) begin
            if (!reg_wdata[4]) abort = 1'b1;
            else if (reg_wdata[7]) begin
                if (reg_wdata[5]) begin cmd_valid = 1'b1; cmd = CMD_START; end
                else if (eng_hold) begin cmd_valid = 1'b1; cmd = CMD_STOP; end
            end
        end
        if (wr_data && stat_q[4] && stat_q[5] && !ctrl_q[4] && stat_q[7:6] == MODE_MTX) begin
            cmd_valid = 1'b1; cmd = CMD_TX;
        end
        if (rd_data && stat_q[5] && !ctrl_q[4] && stat_q[7:6] == MODE_MRX) begin
            cmd_valid = 1'b1; cmd = CMD_RX;
        end
    end

    assign launch = cmd_valid && eng_ready && !abort;

    i2cm_tick #(.QTR_DIV(QTR_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .clear(launch), .tick(tick)
    );

    i2cm_engine u_eng (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cmd_valid(launch), .cmd(cmd),
        .tx_byte(wr_data ? reg_wdata : data_q),
        .ack_en(ctrl_q[7]), .abort(abort), .sda_in(sda_in),
        .ready(eng_ready), .holding(eng_hold), .done(eng_done),
        .rx_byte(eng_rx), .nack(eng_nack),
        .scl_low(scl_low), .sda_low(sda_low)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q        <= 8'h00;
            stat_q        <= 8'h00;
            own_q         <= 8'hFF;
            data_q        <= 8'hFF;
            line_q        <= 8'h00;
            rx_inflight_q <= 1'b0;
        end else begin
            if (eng_done) begin
                if (rx_inflight_q) data_q <= eng_rx;
                stat_q[0] <= !rx_inflight_q && eng_nack && ctrl_q[7];
                if (ctrl_q[5]) ctrl_q[4] <= 1'b1;
            end
            if (launch) begin
                rx_inflight_q <= (cmd == CMD_RX);
                if (cmd == CMD_TX || cmd == CMD_RX) stat_q[0] <= 1'b0;
            end
            if (wr_ctrl) begin
                ctrl_q <= {reg_wdata[7:5], ctrl_q[4] && reg_wdata[4], reg_wdata[3:0]};
                if (pend_clear && !reg_wdata[5]) stat_q[5] <= 1'b0;
            end
            if (wr_stat) begin
                stat_q <= {reg_wdata[7:6], stat_q[5], reg_wdata[4:0]};
                if (!reg_wdata[4]) begin
                    stat_q[5] <= 1'b0;
                    ctrl_q[4] <= 1'b0;
                end else if (reg_wdata[7]) begin
                    if (reg_wdata[5]) begin
                        stat_q[0] <= 1'b0;
                        stat_q[5] <= 1'b1;
                    end else if (!ctrl_q[4]) begin
                        stat_q[5] <= 1'b0;
                    end
                end
            end
            if (reg_wr && hit_own && !stat_q[4]) own_q <= reg_wdata;
            if (wr_data && stat_q[4])            data_q <= reg_wdata;
            if (reg_wr && hit_line)              line_q <= reg_wdata;
        end
    end

    assign irq = ctrl_q[4];

    always_comb begin
        reg_rdata = 8'h00;
        if (hit_ctrl)      reg_rdata = ctrl_q;
        else if (hit_stat) reg_rdata = stat_q;
        else if (hit_own)  reg_rdata = own_q;
        else if (hit_data) reg_rdata = data_q;
        else if (hit_line) reg_rdata = line_q;
    end

    // R6: pending can only rise while interrupts are enabled
    assert_pend_needs_ie_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q[4]) |-> $past(ctrl_q[5]));
    // R4: output-enable-off write leaves no interrupt and no busy
    assert_oe_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !reg_wdata[4]) |=> (!irq && !stat_q[5]));
    // R2: a control write cannot raise the pending flag
    assert_no_sw_set_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !ctrl_q[4] && !eng_done) |=> !ctrl_q[4]);
    // R11: clock held low while pending after a byte
    assert_scl_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[4] && eng_hold) |-> scl_low);
    // R8: own address locked while output is enabled
    assert_own_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit_own && stat_q[4]) |=> $stable(own_q));
endmodule

// File: tb/i2cm_ctrl_test.sv
module i2cm_ctrl_test;
    localparam logic [6:0] TGT       = 7'h52;
    localparam logic [7:0] NACK_BYTE = 8'hEE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq, scl_low, sda_low;
    logic       tgt_pull = 1'b0;
    logic       scl_bus, sda_bus;

    int tests = 0, fails = 0;
    logic [7:0] exp_q[$];
    logic [7:0] rd_pat [2] = '{8'h96, 8'h5A};

    always #4 clk = !clk;

    assign scl_bus = !scl_low;
    assign sda_bus = !(sda_low || tgt_pull);

    i2cm_ctrl #(.ADDR_W(5), .QTR_DIV(2)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .scl_low(scl_low), .sda_low(sda_low), .sda_in(sda_bus)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // target model and scoreboard monitor
    logic       p_scl = 1'b1, p_sda = 1'b1, started = 1'b0, first = 1'b0;
    logic       in_addr = 1'b0, sel = 1'b0, rd_mode = 1'b0, mack_last = 1'b1;
    logic [3:0] cur = '0;
    logic [7:0] shift = '0;
    int         rd_idx = 0, start_cnt = 0, stop_cnt = 0, data_cnt = 0;

    task automatic pop_cmp(input logic [7:0] got);
        tests++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R3: got byte %02h expected none", got);
        end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            if (got !== e) begin
                fails++;
                $display("FAIL R3: got byte %02h expected %02h", got, e);
            end
        end
    endtask

    always @(negedge clk) begin
        if (p_scl && scl_bus && p_sda && !sda_bus) begin
            start_cnt++; started = 1; in_addr = 1; sel = 0; rd_mode = 0;
            tgt_pull = 0; first = 1; cur = 0;
        end else if (p_scl && scl_bus && !p_sda && sda_bus) begin
            stop_cnt++; started = 0; sel = 0; tgt_pull = 0;
        end else if (!p_scl && scl_bus && started) begin
            if (cur < 8) shift = {shift[6:0], sda_bus};
            else if (sel && rd_mode && !in_addr) begin
                mack_last = sda_bus; rd_idx++;
                if (sda_bus) rd_mode = 0;
            end
        end else if (p_scl && !scl_bus && started) begin
            if (first) begin first = 0; cur = 0; end
            else if (cur == 8) begin cur = 0; in_addr = 0; end
            else cur = cur + 1;
            if (cur == 8) begin
                if (in_addr) begin
                    pop_cmp(shift);
                    sel = (shift[7:1] == TGT); rd_mode = shift[0];
                    tgt_pull = sel; rd_idx = 0;
                end else if (sel && !rd_mode) begin
                    pop_cmp(shift); data_cnt++;
                    tgt_pull = (shift != NACK_BYTE);
                end else tgt_pull = 0;
            end else if (sel && rd_mode && !in_addr && rd_idx < 2)
                tgt_pull = !rd_pat[rd_idx][7 - cur];
            else tgt_pull = 0;
        end
        p_scl = scl_bus; p_sda = sda_bus;
    end

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] v);
        @(negedge clk); reg_addr = a; reg_rd = 1; #1 v = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 3000) begin @(negedge clk); n++; end
        chk(req, {7'd0, irq}, 8'h01);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] v;
        int nb;
        repeat (5) @(negedge clk);
        rst_n = 1;
        // R9 reset state
        rd(5'h00, v); chk("R9 ctrl", v, 8'h00);
        rd(5'h04, v); chk("R9 stat", v, 8'h00);
        rd(5'h08, v); chk("R9 own", v, 8'hFF);
        rd(5'h0C, v); chk("R9 data", v, 8'hFF);
        rd(5'h10, v); chk("R9 line", v, 8'h00);
        chk("R9 lines", {irq, scl_low, sda_low}, 8'h00);
        // R1 map
        wr(5'h10, 8'h3C); rd(5'h10, v); chk("R1 line rw", v, 8'h3C);
        rd(5'h14, v); chk("R1 unmapped", v, 8'h00);
        rd(5'h1C, v); chk("R1 unmapped hi", v, 8'h00);
        // R2 pending not settable
        wr(5'h00, 8'h10); rd(5'h00, v); chk("R2 no set", v, 8'h00);
        chk("R2 irq", {7'd0, irq}, 8'h00);
        // R8 write locks
        wr(5'h08, 8'h77); rd(5'h08, v); chk("R8 own oe0", v, 8'h77);
        wr(5'h0C, 8'h11); rd(5'h0C, v); chk("R8 data oe0", v, 8'hFF);
        wr(5'h04, 8'hD0); rd(5'h04, v); chk("R3 mode", v, 8'hD0);
        wr(5'h08, 8'h22); rd(5'h08, v); chk("R8 own oe1", v, 8'h77);
        wr(5'h0C, 8'hA4); rd(5'h0C, v); chk("R8 data oe1", v, 8'hA4);
        // R3 start + address write
        wr(5'h00, 8'hA0);
        exp_q.push_back(8'hA4);
        wr(5'h04, 8'hF0);
        rd(5'h04, v); chk("R3 busy", v & 8'h20, 8'h20);
        wait_irq("R3 addr irq");
        rd(5'h04, v); chk("R6 addr ack", v, 8'hF0);
        chk("R3 start seen", 8'(start_cnt), 8'd1);
        idle(20);
        chk("R11 scl held", {7'd0, scl_low}, 8'h01);
        // R7 data write while pending does not send
        nb = data_cnt;
        wr(5'h0C, 8'h3C); idle(60);
        chk("R7 no send while pending", 8'(data_cnt), 8'(nb));
        exp_q.push_back(8'h3C);
        wr(5'h00, 8'hA0);
        wait_irq("R7 resume tx");
        chk("R7 byte sent", 8'(data_cnt), 8'(nb + 1));
        rd(5'h04, v); chk("R6 data ack", v & 8'h01, 8'h00);
        // R6 NACK recorded
        wr(5'h0C, NACK_BYTE); exp_q.push_back(NACK_BYTE);
        wr(5'h00, 8'hA0); wait_irq("R6 nack irq");
        rd(5'h04, v); chk("R6 nack bit", v & 8'h01, 8'h01);
        wr(5'h0C, NACK_BYTE); exp_q.push_back(NACK_BYTE);
        wr(5'h00, 8'h20); wait_irq("R6 noack irq");
        rd(5'h04, v); chk("R6 nack ignored", v & 8'h01, 8'h00);
        // R5 stop while pending keeps busy
        wr(5'h04, 8'hD0); idle(40);
        chk("R5 stop seen", 8'(stop_cnt), 8'd1);
        rd(5'h04, v); chk("R5 busy kept", v & 8'h20, 8'h20);
        chk("R5 released", {6'd0, scl_low, sda_low}, 8'h00);
        nb = data_cnt;
        wr(5'h00, 8'h00);
        rd(5'h04, v); chk("R7 busy cleared", v & 8'h20, 8'h00);
        idle(100);
        chk("R7 no byte", 8'(data_cnt), 8'(nb));
        chk("R7 irq low", {7'd0, irq}, 8'h00);
        // R10 receive
        wr(5'h00, 8'hA0); wr(5'h0C, 8'hA5); exp_q.push_back(8'hA5);
        wr(5'h04, 8'hB0); wait_irq("R3 rx addr");
        rd(5'h04, v); chk("R6 rx addr ack", v & 8'h01, 8'h00);
        wr(5'h00, 8'hA0); wait_irq("R7 resume rx");
        rd(5'h0C, v); chk("R10 rx byte0", v, 8'h96);
        chk("R10 master ack", {7'd0, mack_last}, 8'h00);
        wr(5'h00, 8'h20); wait_irq("R7 rx second");
        rd(5'h0C, v); chk("R10 rx byte1", v, 8'h5A);
        chk("R10 master nack", {7'd0, mack_last}, 8'h01);
        wr(5'h00, 8'h00); wr(5'h04, 8'h90); idle(40);
        chk("R5 stop after rx", 8'(stop_cnt), 8'd2);
        // R6 address NACK
        wr(5'h00, 8'hA0); wr(5'h04, 8'hD0); wr(5'h0C, 8'h60);
        exp_q.push_back(8'h60);
        wr(5'h04, 8'hF0); wait_irq("R6 addr nack irq");
        rd(5'h04, v); chk("R6 addr nack", v & 8'h01, 8'h01);
        // R4 output disable
        wr(5'h04, 8'h00);
        chk("R4 irq", {7'd0, irq}, 8'h00);
        rd(5'h04, v); chk("R4 busy", v & 8'h20, 8'h00);
        rd(5'h00, v); chk("R4 pend", v & 8'h10, 8'h00);
        idle(4);
        chk("R4 released", {6'd0, scl_low, sda_low}, 8'h00);
        // R6 no pending with interrupts off
        wr(5'h04, 8'hD0); wr(5'h00, 8'h80); wr(5'h0C, 8'hA4);
        exp_q.push_back(8'hA4);
        wr(5'h04, 8'hF0); idle(200);
        chk("R6 ie off irq", {7'd0, irq}, 8'h00);
        rd(5'h00, v); chk("R6 ie off pend", v, 8'h80);
        chk("R3 queue drained", 8'(exp_q.size()), 8'd0);
        wr(5'h04, 8'h00);
        summary();
    end
endmodule